// File: doc/BRIEF.md
# Thresholded Multi-Occurrence Event Counter

This block is one performance monitoring counter. On every clock it is given the number of times a single event occurred in that cycle, which may be more than one. In summing mode it adds that whole number to a wide accumulator. In threshold mode it adds exactly one in each cycle whose occurrence number is strictly above a programmed threshold. Threshold mode therefore counts busy cycles rather than individual occurrences.

Counting is qualified by the current execution context. An instruction-set selector picks the legacy set, the native set or both. A four-bit privilege mask names the privilege levels at which the event is counted. A mask of zero falls back to a separately programmed default mask. Software programs the fields through a small register write port and reads the accumulator directly. Software may also preload the accumulator. A sticky flag records wrap-around until software clears it.

Top module: `evt_thr_counter`

## Requirements
- R1: After reset the count is 0, the overflow flag is 0 and every configuration field is 0. With the privilege mask and the default mask both 0, no event is counted.
- R2: With threshold 0, a qualified cycle adds the full occurrence number (0 to 2^OCC_W-1) to the count.
- R3: With threshold n > 0, a qualified cycle adds 1 when the occurrence number is strictly greater than n, and 0 otherwise.
- R4: Instruction-set selector (control bits [9:8]): 0 counts in both sets, 1 counts only when ctxLegacy is 1, 2 counts only when ctxLegacy is 0. The reserved value 3 behaves like 0.
- R5: Privilege mask (control bits [19:16]): bit i enables counting when ctxPriv equals i.
- R6: When the privilege mask is 0, the default mask (control bits [27:24]) is used in its place with the same bit meaning.
- R7: A write to address 0 loads the threshold (bits [OCC_W-1:0]) and the other control fields, and they take effect from the next clock edge. An event in the same cycle as the write is judged with the old settings.
- R8: The count is CNT_W bits wide and wraps modulo 2^CNT_W. A carry out sets the sticky overflow flag. Writing bit 0 = 1 to address 2 clears it, but a carry in that same cycle keeps it set.
- R9: A write to address 1 loads regWrData into the count. That load takes priority over any event in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| occCount | input | OCC_W | Occurrences of the event in this cycle |
| ctxLegacy | input | 1 | 1 when the legacy instruction set is executing |
| ctxPriv | input | 2 | Current privilege level, 0 to 3 |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Write address: 0 control, 1 count load, 2 overflow clear |
| regWrData | input | CNT_W | Write data |
| countOut | output | CNT_W | Current accumulator value |
| overflow | output | 1 | Sticky wrap-around flag |

## Verification
The assertions assume that occCount reports the real per-cycle occurrence number. They also assume that reset is held for at least one edge before any check depends on history. The bound on the per-cycle growth of the count holds only when no load is written in that cycle. The bench therefore drives occCount to zero around every load and configuration write, except in the directed tests that deliberately overlap them. Every stimulus change is made on the falling edge, so the registered configuration and context are stable at the counting edge.

// File: rtl/evt_thr_pkg.sv
package evt_thr_pkg;

  // Control register field positions (address 0)
  localparam int THR_LSB = 0;
  localparam int ISM_LSB = 8;
  localparam int PLM_LSB = 16;
  localparam int DFL_LSB = 24;

  // Register addresses
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_LOAD = 2'd1;
  localparam logic [1:0] ADDR_CLR  = 2'd2;

  typedef enum logic [1:0] {
    ISM_BOTH   = 2'd0,
    ISM_LEGACY = 2'd1,
    ISM_NATIVE = 2'd2,
    ISM_RSVD   = 2'd3
  } ismSel_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;
    logic clrOvf;
    logic advance;
  } ctrlStrobe_t;

endpackage

// File: rtl/evt_thr_ctrl.sv
module evt_thr_ctrl
  import evt_thr_pkg::*;
#(
  parameter int OCC_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [OCC_W-1:0] occCount,
  input  logic             ctxLegacy,
  input  logic [1:0]       ctxPriv,
  input  logic             regWrEn,
  input  logic [1:0]       regAddr,
  input  logic [OCC_W-1:0] thrIn,
  input  logic [1:0]       ismIn,
  input  logic [3:0]       plmIn,
  input  logic [3:0]       dflIn,
  input  logic             clrBit,
  output ctrlStrobe_t      strobe,
  output logic [OCC_W-1:0] step
);

  logic [OCC_W-1:0] thrQ;
  ismSel_t          ismQ;
  logic [3:0]       plmQ;
  logic [3:0]       dflQ;

  logic [3:0] effMask;
  logic       ismOk;
  logic       privOk;
  logic       loadHit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      thrQ <= '0;
      ismQ <= ISM_BOTH;
      plmQ <= '0;
      dflQ <= '0;
    end else if (regWrEn && regAddr == ADDR_CTRL) begin
      thrQ <= thrIn;
      ismQ <= ismSel_t'(ismIn);
      plmQ <= plmIn;
      dflQ <= dflIn;
    end
  end

  always_comb begin
    unique case (ismQ)
      ISM_LEGACY: ismOk = ctxLegacy;
      ISM_NATIVE: ismOk = !ctxLegacy;
      default:    ismOk = 1'b1;
    endcase
  end

  assign effMask = (plmQ != 4'd0) ? plmQ : dflQ;
  assign privOk  = effMask[ctxPriv];

  always_comb begin
    if (thrQ == '0) step = occCount;
    else            step = (occCount > thrQ) ? OCC_W'(1) : '0;
  end

  assign loadHit        = regWrEn && regAddr == ADDR_LOAD;
  assign strobe.load    = loadHit;
  assign strobe.clrOvf  = regWrEn && regAddr == ADDR_CLR && clrBit;
  assign strobe.advance = ismOk && privOk && !loadHit;

endmodule

// File: rtl/evt_thr_datapath.sv
module evt_thr_datapath
  import evt_thr_pkg::*;
#(
  parameter int CNT_W = 64,
  parameter int OCC_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strobe,
  input  logic [OCC_W-1:0] step,
  input  logic [CNT_W-1:0] loadVal,
  output logic [CNT_W-1:0] countQ,
  output logic             ovfQ
);

  localparam int PAD_W = CNT_W + 1 - OCC_W;

  logic [CNT_W:0] sumExt;
  logic           carry;

  assign sumExt = {1'b0, countQ} + {{PAD_W{1'b0}}, step};
  assign carry  = strobe.advance && sumExt[CNT_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countQ <= '0;
    end else if (strobe.load) begin
      countQ <= loadVal;
    end else if (strobe.advance) begin
      countQ <= sumExt[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)              ovfQ <= 1'b0;
    else if (carry)         ovfQ <= 1'b1;
    else if (strobe.clrOvf) ovfQ <= 1'b0;
  end

endmodule

// File: rtl/evt_thr_counter.sv
module evt_thr_counter
  import evt_thr_pkg::*;
#(
  parameter int CNT_W = 64,
  parameter int OCC_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [OCC_W-1:0] occCount,
  input  logic             ctxLegacy,
  input  logic [1:0]       ctxPriv,
  input  logic             regWrEn,
  input  logic [1:0]       regAddr,
  input  logic [CNT_W-1:0] regWrData,
  output logic [CNT_W-1:0] countOut,
  output logic             overflow
);

  ctrlStrobe_t      strobe;
  logic [OCC_W-1:0] step;

  evt_thr_ctrl #(.OCC_W(OCC_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .occCount (occCount),
    .ctxLegacy(ctxLegacy),
    .ctxPriv  (ctxPriv),
    .regWrEn  (regWrEn),
    .regAddr  (regAddr),
    .thrIn    (regWrData[THR_LSB +: OCC_W]),
    .ismIn    (regWrData[ISM_LSB +: 2]),
    .plmIn    (regWrData[PLM_LSB +: 4]),
    .dflIn    (regWrData[DFL_LSB +: 4]),
    .clrBit   (regWrData[0]),
    .strobe   (strobe),
    .step     (step)
  );

  evt_thr_datapath #(.CNT_W(CNT_W), .OCC_W(OCC_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .step   (step),
    .loadVal(regWrData),
    .countQ (countOut),
    .ovfQ   (overflow)
  );

endmodule

// File: rtl/evt_thr_counter_chk.sv
module evt_thr_counter_chk
  import evt_thr_pkg::*;
#(
  parameter int CNT_W = 64,
  parameter int OCC_W = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic [OCC_W-1:0] occCount,
  input logic             regWrEn,
  input logic [1:0]       regAddr,
  input logic [CNT_W-1:0] regWrData,
  input logic [CNT_W-1:0] countOut,
  input logic             overflow
);

  logic loadWr;
  logic clrWr;
  assign loadWr = regWrEn && regAddr == ADDR_LOAD;
  assign clrWr  = regWrEn && regAddr == ADDR_CLR && regWrData[0];

  // R2 / R3: growth per cycle never exceeds the occurrence number
  a_r2_growth_bound: assert property (@(posedge clk) disable iff (!rstN)
    !loadWr |=> (countOut - $past(countOut)) <= CNT_W'($past(occCount)));

  // R2: no occurrences and no load keeps the count still
  a_r2_idle_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!loadWr && occCount == '0) |=> $stable(countOut));

  // R9: a load write lands in the count
  a_r9_load_value: assert property (@(posedge clk) disable iff (!rstN)
    loadWr |=> countOut == $past(regWrData));

  // R8: overflow is sticky without a clear
  a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (overflow && !clrWr) |=> overflow);

  // R8: overflow rises only when the count wraps
  a_r8_ovf_on_wrap: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overflow) |-> countOut < $past(countOut));

  // R8: a clear with no occurrences drops the flag
  a_r8_clear_works: assert property (@(posedge clk) disable iff (!rstN)
    (clrWr && occCount == '0) |=> !overflow);

endmodule

bind evt_thr_counter evt_thr_counter_chk #(.CNT_W(CNT_W), .OCC_W(OCC_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .occCount (occCount),
  .regWrEn  (regWrEn),
  .regAddr  (regAddr),
  .regWrData(regWrData),
  .countOut (countOut),
  .overflow (overflow)
);

// File: tb/evt_thr_counter_tb.sv
`timescale 1ns/1ps
module evt_thr_counter_tb;

  localparam int CNT_W = 64;
  localparam int OCC_W = 3;

  logic             clk = 1'b0;
  logic             rstN;
  logic [OCC_W-1:0] occCount;
  logic             ctxLegacy;
  logic [1:0]       ctxPriv;
  logic             regWrEn;
  logic [1:0]       regAddr;
  logic [CNT_W-1:0] regWrData;
  logic [CNT_W-1:0] countOut;
  logic             overflow;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  evt_thr_counter #(.CNT_W(CNT_W), .OCC_W(OCC_W)) u_dut (
    .clk(clk), .rstN(rstN), .occCount(occCount), .ctxLegacy(ctxLegacy),
    .ctxPriv(ctxPriv), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .countOut(countOut), .overflow(overflow)
  );

  typedef struct packed {
    logic [2:0] thr;
    logic [1:0] ism;
    logic [3:0] plm;
    logic [3:0] dfl;
    logic       leg;
    logic [1:0] priv;
    logic [2:0] occ;
    logic [2:0] exp;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{3'd0, 2'd0, 4'hF, 4'h0, 1'b0, 2'd0, 3'd6, 3'd6}, // R2
    '{3'd0, 2'd0, 4'hF, 4'h0, 1'b1, 2'd3, 3'd3, 3'd3}, // R2
    '{3'd5, 2'd0, 4'hF, 4'h0, 1'b0, 2'd0, 3'd6, 3'd1}, // R3
    '{3'd5, 2'd0, 4'hF, 4'h0, 1'b0, 2'd0, 3'd5, 3'd0}, // R3
    '{3'd2, 2'd0, 4'hF, 4'h0, 1'b0, 2'd1, 3'd3, 3'd1}, // R3
    '{3'd2, 2'd0, 4'hF, 4'h0, 1'b0, 2'd1, 3'd0, 3'd0}, // R3
    '{3'd0, 2'd1, 4'hF, 4'h0, 1'b0, 2'd0, 3'd4, 3'd0}, // R4
    '{3'd0, 2'd1, 4'hF, 4'h0, 1'b1, 2'd0, 3'd4, 3'd4}, // R4
    '{3'd0, 2'd2, 4'hF, 4'h0, 1'b1, 2'd0, 3'd4, 3'd0}, // R4
    '{3'd0, 2'd2, 4'hF, 4'h0, 1'b0, 2'd0, 3'd2, 3'd2}, // R4
    '{3'd0, 2'd3, 4'hF, 4'h0, 1'b1, 2'd0, 3'd1, 3'd1}, // R4
    '{3'd0, 2'd0, 4'h4, 4'h0, 1'b0, 2'd2, 3'd5, 3'd5}, // R5
    '{3'd0, 2'd0, 4'h4, 4'h0, 1'b0, 2'd1, 3'd5, 3'd0}, // R5
    '{3'd0, 2'd0, 4'h0, 4'h8, 1'b0, 2'd3, 3'd2, 3'd2}, // R6
    '{3'd0, 2'd0, 4'h0, 4'h8, 1'b0, 2'd0, 3'd2, 3'd0}, // R6
    '{3'd0, 2'd0, 4'h0, 4'h0, 1'b0, 2'd3, 3'd7, 3'd0}  // R6
  };

  function automatic logic [CNT_W-1:0] ctrlWord(logic [2:0] thr, logic [1:0] ism,
                                                logic [3:0] plm, logic [3:0] dfl);
    logic [CNT_W-1:0] w = '0;
    w[2:0]   = thr;
    w[9:8]   = ism;
    w[19:16] = plm;
    w[27:24] = dfl;
    return w;
  endfunction

  task automatic check(string req, logic [CNT_W-1:0] act, logic [CNT_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic writeReg(logic [1:0] addr, logic [CNT_W-1:0] data);
    regWrEn = 1'b1; regAddr = addr; regWrData = data;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; occCount = '0; ctxLegacy = 1'b0; ctxPriv = 2'd0;
    regWrEn = 1'b0; regAddr = '0; regWrData = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state, and nothing counts with both masks zero
    check("R1 count", countOut, '0);
    check("R1 ovf", {63'd0, overflow}, 64'd0);
    occCount = 3'd6; ctxPriv = 2'd0;
    @(negedge clk);
    occCount = '0;
    check("R1 masks zero", countOut, '0);

    for (int i = 0; i < NV; i++) begin
      writeReg(2'd0, ctrlWord(VEC[i].thr, VEC[i].ism, VEC[i].plm, VEC[i].dfl));
      writeReg(2'd1, '0);
      ctxLegacy = VEC[i].leg; ctxPriv = VEC[i].priv; occCount = VEC[i].occ;
      @(negedge clk);
      occCount = '0;
      check($sformatf("R2-vector %0d", i), countOut, CNT_W'(VEC[i].exp));
    end

    // R7: config written in the same cycle as an event applies one edge later
    ctxLegacy = 1'b0; ctxPriv = 2'd0;
    writeReg(2'd0, ctrlWord(3'd0, 2'd0, 4'hF, 4'h0));
    writeReg(2'd1, '0);
    occCount = 3'd4;
    writeReg(2'd0, ctrlWord(3'd5, 2'd0, 4'hF, 4'h0));
    check("R7 old config", countOut, 64'd4);
    @(negedge clk);
    occCount = '0;
    check("R7 new config", countOut, 64'd4);

    // R8: wrap and sticky overflow
    writeReg(2'd0, ctrlWord(3'd0, 2'd0, 4'hF, 4'h0));
    writeReg(2'd1, {CNT_W{1'b1}} - 64'd1);
    occCount = 3'd5;
    @(negedge clk);
    occCount = '0;
    check("R8 wrap value", countOut, 64'd3);
    check("R8 ovf set", {63'd0, overflow}, 64'd1);
    repeat (3) @(negedge clk);
    check("R8 ovf sticky", {63'd0, overflow}, 64'd1);
    writeReg(2'd2, 64'd1);
    check("R8 ovf cleared", {63'd0, overflow}, 64'd0);
    // R8: set wins over clear in the same cycle
    writeReg(2'd1, {CNT_W{1'b1}});
    occCount = 3'd1;
    writeReg(2'd2, 64'd1);
    occCount = '0;
    check("R8 set beats clear", {63'd0, overflow}, 64'd1);
    check("R8 wrap to zero", countOut, 64'd0);

    // R9: load wins over a simultaneous event
    occCount = 3'd6;
    writeReg(2'd1, 64'd100);
    occCount = '0;
    check("R9 load priority", countOut, 64'd100);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule